// File: doc/BRIEF.md
# Interrupt Return Stack Unwinder

This block performs the stack side of a return-from-interrupt in a small CPU core. When the core's decode logic strobes `start_i`, the sequencer reads a saved frame from a byte-wide stack memory, one byte at a time. It starts at the current stack pointer and walks downward. From the bytes it reads it rebuilds a 24-bit program counter and, in extended mode, the secondary status byte. It then reports the new program counter, the lowered stack pointer and the status byte.

Two frame formats are supported, and the mode input picks one of them:

- **Short frame:** two bytes hold a 16-bit return address. The top address byte is forced so that execution resumes in the highest 64 KB region.
- **Extended frame:** four bytes hold a full 24-bit return address and the saved secondary status byte. The primary status byte is never part of either frame.

The completion strobe is timed so that the whole operation takes a fixed number of cycles in each mode. At completion the block also pulses a release towards the interrupt priority logic, so the level just serviced can be taken again. It then raises a hold flag that blocks further equal-or-lower-priority interrupts until one instruction has retired.

Top module: `irq_return_seq`

## Requirements
- R1: With `ext_mode_i` = 0, exactly two reads are issued, at addresses SP and SP-1. The stack pointer result is SP-2, computed modulo 2^SP_W.
- R2: With `ext_mode_i` = 0, `pc_o[7:0]` is the byte read at SP and `pc_o[15:8]` is the byte read at SP-1. `pc_o[23:16]` is FFh.
- R3: With `ext_mode_i` = 0, `stat_o` equals the value on `stat_cur_i` in the cycle that `start_i` was accepted. A later change on `stat_cur_i` has no effect on it.
- R4: With `ext_mode_i` = 1, four reads are issued, at SP, SP-1, SP-2 and SP-3. Their bytes become, in that order, `pc_o[7:0]`, `pc_o[15:8]`, `pc_o[23:16]` and `stat_o`. The stack pointer result is SP-4, modulo 2^SP_W.
- R5: If `start_i` is sampled high on a clock edge, `done_o` is high in the cycle that follows the 9th such edge in short mode, or the 12th in extended mode. That edge counts as the first. `busy_o` is high from the first of these edges until the end of the done cycle. `done_o` is high only while `busy_o` is high.
- R6: `release_o` is a single-cycle pulse that coincides with `done_o` in both modes.
- R7: `hold_o` rises on the edge that ends the done cycle. It falls on the first later edge at which `retire_i` is high.
- R8: A `start_i` pulse that arrives while `busy_o` is high is ignored. It produces no extra completion and does not change the operation in progress.
- R9: Each read is a one-cycle `mem_rd_o` pulse. The byte is taken from `mem_rdata_i` in the cycle that follows, so the memory must return data one cycle after the address.
- R10: `pc_o`, `sp_o` and `stat_o` are valid in the done cycle and hold their values until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a return sequence |
| ext_mode_i | input | 1 | 0 = two-byte frame, 1 = four-byte frame |
| sp_i | input | SP_W | Stack pointer at start |
| stat_cur_i | input | 8 | Current secondary status byte |
| retire_i | input | 1 | One instruction retired |
| mem_rd_o | output | 1 | Stack read strobe |
| mem_addr_o | output | SP_W | Stack read address |
| mem_rdata_i | input | 8 | Stack read data, one cycle after the address |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last cycle of the sequence |
| pc_o | output | 24 | Restored program counter |
| sp_o | output | SP_W | Stack pointer after the pops |
| stat_o | output | 8 | Secondary status byte after the return |
| release_o | output | 1 | Re-enable the serviced priority level |
| hold_o | output | 1 | Block equal/lower-priority interrupts for one instruction |

## Verification
The assertions check several properties on every cycle:

- the completion strobe only ever appears inside a busy window;
- a start that is accepted arms the counter at zero;
- a start received while busy leaves the latched mode and stack pointer unchanged;
- read strobes never span two cycles;
- the release pulse is a single cycle;
- the hold flag rises after each completion and clears on a retire.

The scenarios show what no single-cycle property can capture:

- the byte-to-field mapping of each frame, including wrap of the stack pointer through zero;
- the exact 9- and 12-cycle completion latency;
- the capture of the status byte at start in short mode;
- the absence of a second completion after a start that arrives while busy.

// File: rtl/irq_ret_pkg.sv
// Package: shared constants and types for the interrupt return unwinder.
// Assumes byte-wide stack memory and a three-byte program counter.
package irq_ret_pkg;
    localparam int BYTE_W      = 8;
    localparam int PC_BYTES    = 3;
    localparam int SHORT_POPS  = 2;
    localparam int EXT_POPS    = 4;
    localparam int PC_W        = BYTE_W * PC_BYTES;

    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/ret_seq_ctl.sv
// Module: ret_seq_ctl
// Step counter and pop scheduler. It accepts a start when idle, latches the
// mode and the stack pointer, and then counts states. Even steps present a
// read and odd steps capture its data, until all pops of the frame are done.
// done_o marks the last state. Assumes each state count >= 2 * its pop count.
module ret_seq_ctl
    import irq_ret_pkg::*;
#(
    parameter int SP_W         = 8,
    parameter int SHORT_STATES = 9,
    parameter int EXT_STATES   = 12,
    parameter int CNT_W        = $clog2(EXT_STATES),
    parameter int IDX_W        = CNT_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ext_i,
    input  logic [SP_W-1:0]  sp_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             ext_o,
    output logic [SP_W-1:0]  sp_base_o,
    output logic [IDX_W-1:0] pop_idx_o,
    output logic             rd_phase_o,
    output logic             cap_phase_o
);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_STATES - 1);
    localparam logic [CNT_W-1:0] LAST_EXT   = CNT_W'(EXT_STATES - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ext_q;
    logic [SP_W-1:0]  sp_base_q;
    logic [CNT_W-1:0] last_step;
    logic [IDX_W-1:0] pops_n;
    logic             pop_live;

    // Last step index and number of pops for the latched mode
    always_comb begin
        last_step = ext_q ? LAST_EXT : LAST_SHORT;
        pops_n    = ext_q ? IDX_W'(EXT_POPS) : IDX_W'(SHORT_POPS);
    end

    assign accept_o    = start_i && !busy_q;
    assign done_o      = busy_q && (cnt_q == last_step);
    assign pop_idx_o   = cnt_q[CNT_W-1:1];
    assign pop_live    = busy_q && (pop_idx_o < pops_n);
    assign rd_phase_o  = pop_live && !cnt_q[0];
    assign cap_phase_o = pop_live && cnt_q[0];
    assign busy_o      = busy_q;
    assign ext_o       = ext_q;
    assign sp_base_o   = sp_base_q;

    // Accept a start when idle, advance the step count, drop busy at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            cnt_q     <= '0;
            ext_q     <= 1'b0;
            sp_base_q <= '0;
        end else if (accept_o) begin
            busy_q    <= 1'b1;
            cnt_q     <= '0;
            ext_q     <= ext_i;
            sp_base_q <= sp_i;
        end else if (busy_q) begin
            if (cnt_q == last_step) begin
                busy_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R5
    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && cnt_q == '0)); // R5
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && busy_o && !done_o) |=> ($stable(ext_q) && $stable(sp_base_q))); // R8
    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_phase_o |=> !rd_phase_o); // R9
endmodule

// File: rtl/ret_frame_asm.sv
// Module: ret_frame_asm
// Frame assembler. It stores each popped byte in the slot for its pop
// index and builds the program counter and the status byte from the slots.
// In short mode the status byte latched at start is kept and the top PC byte
// is forced to the fixed region. Assumes the read data is valid whenever
// cap_i is high.
module ret_frame_asm
    import irq_ret_pkg::*;
#(
    parameter int          IDX_W      = 3,
    parameter logic [7:0]  TOP_REGION = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept_i,
    input  logic             ext_i,
    input  byte_t            stat_cur_i,
    input  logic             cap_i,
    input  logic [IDX_W-1:0] idx_i,
    input  byte_t            rdata_i,
    output logic [PC_W-1:0]  pc_o,
    output byte_t            stat_o
);
    byte_t slot_q [EXT_POPS];
    byte_t stat_keep_q;

    // One capture register per pop position
    for (genvar g = 0; g < EXT_POPS; g++) begin : g_slot
        // Capture the popped byte when its pop index is served
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (cap_i && (idx_i == IDX_W'(g))) begin
                slot_q[g] <= rdata_i;
            end
        end
    end

    // Keep the current secondary status for short-frame returns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_keep_q <= '0;
        end else if (accept_i) begin
            stat_keep_q <= stat_cur_i;
        end
    end

    // Select the output fields for the latched frame format
    always_comb begin
        pc_o[7:0]   = slot_q[0];
        pc_o[15:8]  = slot_q[1];
        pc_o[23:16] = ext_i ? slot_q[2] : TOP_REGION;
        stat_o      = ext_i ? slot_q[3] : stat_keep_q;
    end

    AST_CAPTURE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_i |=> !cap_i); // R9
endmodule

// File: rtl/ret_hold_ctl.sv
// Module: ret_hold_ctl
// Interrupt hold flag. It is set by the completion of a return and cleared
// by the next instruction-retire pulse. If both happen on the same edge, the
// set wins.
module ret_hold_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic retire_i,
    output logic hold_o
);
    logic hold_q;

    // Set on completion, clear on the first retire afterwards
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else if (done_i) begin
            hold_q <= 1'b1;
        end else if (retire_i) begin
            hold_q <= 1'b0;
        end
    end

    assign hold_o = hold_q;

    AST_HOLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> hold_o); // R7
    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_o && retire_i && !done_i) |=> !hold_o); // R7
endmodule

// File: rtl/irq_return_seq.sv
// Module: irq_return_seq (top)
// Return-from-interrupt stack unwinder. It pops a two-byte or four-byte frame
// from a byte-wide stack memory with one-cycle read latency, and returns the
// new PC, SP and status byte. On completion it pulses the priority release
// and raises a one-instruction interrupt hold. Assumes start_i is only
// meaningful while idle.
module irq_return_seq
    import irq_ret_pkg::*;
#(
    parameter int          SP_W         = 8,
    parameter int          SHORT_STATES = 9,
    parameter int          EXT_STATES   = 12,
    parameter logic [7:0]  TOP_REGION   = 8'hFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ext_mode_i,
    input  logic [SP_W-1:0]  sp_i,
    input  logic [7:0]       stat_cur_i,
    input  logic             retire_i,
    output logic             mem_rd_o,
    output logic [SP_W-1:0]  mem_addr_o,
    input  logic [7:0]       mem_rdata_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [23:0]      pc_o,
    output logic [SP_W-1:0]  sp_o,
    output logic [7:0]       stat_o,
    output logic             release_o,
    output logic             hold_o
);
    localparam int CNT_W = $clog2(EXT_STATES);
    localparam int IDX_W = CNT_W - 1;

    logic             accept;
    logic             ext_q;
    logic [SP_W-1:0]  sp_base;
    logic [IDX_W-1:0] pop_idx;
    logic             cap_phase;

    ret_seq_ctl #(
        .SP_W(SP_W), .SHORT_STATES(SHORT_STATES), .EXT_STATES(EXT_STATES),
        .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_ctl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_i(ext_mode_i),
        .sp_i(sp_i), .accept_o(accept), .busy_o(busy_o), .done_o(done_o),
        .ext_o(ext_q), .sp_base_o(sp_base), .pop_idx_o(pop_idx),
        .rd_phase_o(mem_rd_o), .cap_phase_o(cap_phase)
    );

    ret_frame_asm #(.IDX_W(IDX_W), .TOP_REGION(TOP_REGION)) u_asm (
        .clk(clk), .rst_n(rst_n), .accept_i(accept), .ext_i(ext_q),
        .stat_cur_i(stat_cur_i), .cap_i(cap_phase), .idx_i(pop_idx),
        .rdata_i(mem_rdata_i), .pc_o(pc_o), .stat_o(stat_o)
    );

    ret_hold_ctl u_hold (
        .clk(clk), .rst_n(rst_n), .done_i(done_o), .retire_i(retire_i),
        .hold_o(hold_o)
    );

    // Read address walks down from the latched SP; result SP drops by the frame size
    assign mem_addr_o = sp_base - SP_W'(pop_idx);
    assign sp_o       = sp_base - (ext_q ? SP_W'(EXT_POPS) : SP_W'(SHORT_POPS));
    assign release_o  = done_o;

    AST_RELEASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        release_o |=> !release_o); // R6
    AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> busy_o); // R9
endmodule

// File: tb/irq_return_seq_tb.sv
module irq_return_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        ext_mode_i = 1'b0;
    logic [7:0]  sp_i = '0;
    logic [7:0]  stat_cur_i = '0;
    logic        retire_i = 1'b0;
    logic        mem_rd_o;
    logic [7:0]  mem_addr_o;
    logic [7:0]  mem_rdata_i = '0;
    logic        busy_o, done_o, release_o, hold_o;
    logic [23:0] pc_o;
    logic [7:0]  sp_o, stat_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] mem [256];

    typedef struct {
        logic [23:0] pc;
        logic [7:0]  sp;
        logic [7:0]  stat;
        int          lat;
        int          t0;
    } exp_t;
    exp_t sbq[$];

    irq_return_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ext_mode_i(ext_mode_i),
        .sp_i(sp_i), .stat_cur_i(stat_cur_i), .retire_i(retire_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .sp_o(sp_o),
        .stat_o(stat_o), .release_o(release_o), .hold_o(hold_o)
    );

    always #5 clk = ~clk;

    // Stack memory model with one-cycle read latency; cycle counter; watchdog
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o];
        if (cyc > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run hung, actual cyc=%0d expected < 20000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: pop an expected item at each completion and compare
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sbq.size() == 0) begin
                checks = checks + 1;
                errors = errors + 1;
                $display("FAIL R8: actual unexpected done, expected none");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check("R2/R4 pc", {8'h0, pc_o}, {8'h0, e.pc});
                check("R1/R4 sp", {24'h0, sp_o}, {24'h0, e.sp});
                check("R3/R4 stat", {24'h0, stat_o}, {24'h0, e.stat});
                check("R5 latency", cyc - e.t0, e.lat);
                check("R6 release", {31'h0, release_o}, 32'h1);
            end
        end
    end

    // Driver: compute the expected frame result, push it, pulse start
    task automatic run_ret(input logic ext, input logic [7:0] sp, input logic [7:0] scur);
        exp_t e;
        if (ext) begin
            e.pc   = {mem[sp - 8'd2], mem[sp - 8'd1], mem[sp]};
            e.stat = mem[sp - 8'd3];
            e.sp   = sp - 8'd4;
            e.lat  = 12;
        end else begin
            e.pc   = {8'hFF, mem[sp - 8'd1], mem[sp]};
            e.stat = scur;
            e.sp   = sp - 8'd2;
            e.lat  = 9;
        end
        @(negedge clk);
        e.t0 = cyc;
        sbq.push_back(e);
        ext_mode_i = ext;
        sp_i = sp;
        stat_cur_i = scur;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R5 busy after start", {31'h0, busy_o}, 32'h1);
        stat_cur_i = ~scur;  // change after start must not matter (R3)
    endtask

    task automatic wait_done();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic retire_pulse();
        @(negedge clk);
        retire_i = 1'b1;
        @(negedge clk);
        retire_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        check("R5 reset busy", {31'h0, busy_o}, 32'h0);
        check("R5 reset done", {31'h0, done_o}, 32'h0);
        check("R6 reset release", {31'h0, release_o}, 32'h0);
        check("R7 reset hold", {31'h0, hold_o}, 32'h0);
        check("R9 reset read", {31'h0, mem_rd_o}, 32'h0);
        rst_n = 1'b1;

        // R1 R2: worked case, SP=0Bh, [0Ah]=01h, [0Bh]=23h -> PC FF0123h, SP 09h
        mem[8'h0A] = 8'h01;
        mem[8'h0B] = 8'h23;
        run_ret(1'b0, 8'h0B, 8'h5A);
        wait_done();
        check("R7 hold after done", {31'h0, hold_o}, 32'h1);
        check("R10 pc held", {8'h0, pc_o}, 32'hFF0123);
        check("R10 sp held", {24'h0, sp_o}, 32'h09);
        repeat (2) @(negedge clk);
        check("R7 hold waits for retire", {31'h0, hold_o}, 32'h1);
        retire_pulse();
        check("R7 hold cleared", {31'h0, hold_o}, 32'h0);

        // R4: extended frame
        mem[8'h20] = 8'h11; mem[8'h1F] = 8'h22; mem[8'h1E] = 8'h33; mem[8'h1D] = 8'hC4;
        run_ret(1'b1, 8'h20, 8'h00);
        wait_done();
        check("R4 stat from stack", {24'h0, stat_o}, 32'hC4);
        retire_pulse();

        // R1 wrap through zero in short mode
        run_ret(1'b0, 8'h01, 8'hA5);
        wait_done();
        retire_pulse();

        // R4 wrap through zero in extended mode
        run_ret(1'b1, 8'h02, 8'h3C);
        wait_done();
        retire_pulse();

        // R8: start during busy is ignored
        run_ret(1'b1, 8'h80, 8'h11);
        repeat (3) @(negedge clk);
        ext_mode_i = 1'b0;
        sp_i = 8'h40;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done();
        repeat (15) @(negedge clk);
        check("R8 no extra completion", {31'h0, busy_o}, 32'h0);
        retire_pulse();

        // R3: short mode after an extended one keeps the captured status
        run_ret(1'b0, 8'hF0, 8'h96);
        wait_done();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule